// File: doc/BRIEF.md
# Register Wakeup Scoreboard

This unit sits beside an out-of-order issue queue. It keeps one ready bit for each renamed physical register, with the integer and floating-point pools counted together. It also records, for every queue entry and every source operand slot, whether that slot is still waiting on a register. When an instruction is written into an entry, each of its source operands is resolved at once. An operand is resolved if the front end already flagged it ready, if its index lies outside the renamed range, if the register's scoreboard bit is set, or if a completion broadcast for that register arrives in the same cycle. Any other operand is left waiting, with its register tag held in the slot.

A completion broadcast names one register. Every waiting slot in every valid entry that holds that tag is released in one cycle, and the register's scoreboard bit is set. The destination of an inserted instruction clears its scoreboard bit. If a still-waiting slot already names that destination, the unit raises an error flag. A squash mask empties the chosen entries and leaves the scoreboard alone. For each entry, the unit reports whether the entry is valid with every source ready. Selection logic reads this flag.

Top module: `sb_wakeup_unit`

## Requirements
- R1: While reset is high at a clock edge, every scoreboard bit, every per-entry ready flag and the conflict flag read 0 after that edge.
- R2: On insert, a source whose front-end ready flag is 1 is not tracked. A source whose register has its scoreboard bit set is also resolved and is not tracked.
- R3: On insert, any other in-range source is recorded as waiting on its tag. An entry's ready flag stays 0 while any of its slots waits.
- R4: A broadcast of an in-range register releases every waiting slot holding that tag in all valid entries, and it sets the register's scoreboard bit. Both take effect after the same clock edge.
- R5: When a broadcast and an insert name the same source register in one cycle, the inserted source counts as ready.
- R6: Register indices at or above the tracked count (32 by default, tags 6 bits wide) are never tracked. Such a source counts as ready, such a destination changes no scoreboard bit, and such a broadcast changes nothing.
- R7: The in-range destination of an inserted instruction clears its scoreboard bit after that edge. If a broadcast names the same register in that cycle, the clear wins.
- R8: `dst_conflict` is 1 for one cycle after an insert whose in-range destination is the tag of a slot already waiting in the queue. A same-cycle broadcast of that tag suppresses the flag. Otherwise it is 0.
- R9: Entries selected by `squash_mask` become invalid and drop their waiting slots, and the scoreboard is unchanged. A later broadcast therefore does not make them ready. An insert to the same entry in that cycle takes priority over the squash.
- R10: `entry_ready[e]` is 1 exactly when entry e is valid and none of its slots waits. Source slot s occupies bits [s*6 +: 6] of `ins_src_tag` and bit s of `ins_src_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Write an instruction into an entry this cycle |
| ins_entry | input | 3 | Entry index being written |
| ins_src_tag | input | 12 | Source register tags, slot s at [s*6 +: 6] |
| ins_src_rdy | input | 2 | Front-end ready flag per source slot |
| ins_dst_valid | input | 1 | Inserted instruction has a destination |
| ins_dst_tag | input | 6 | Destination register tag |
| bcast_valid | input | 1 | Completion broadcast this cycle |
| bcast_tag | input | 6 | Register completed by the broadcast |
| squash_mask | input | 8 | Entries to empty this cycle |
| entry_ready | output | 8 | Entry valid with all sources ready |
| reg_ready | output | 32 | Scoreboard bit per physical register |
| dst_conflict | output | 1 | Destination already had a waiting dependent |

## Verification
Every result is held in a register on the same clock edge that captures its stimulus. The scoreboard bits, the entry ready flags and the conflict flag are therefore all due one edge after the inputs are applied. None of them is due in the same cycle. The bench applies each stimulus at a falling edge and samples the outputs at the very next falling edge, half a period after the capturing rising edge. After each sample it returns the inputs to idle, so an idle cycle never changes any state the later checks depend on.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int TAG_W = 6;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
    } tag_req_t;

    function automatic logic tag_tracked(input logic [TAG_W-1:0] tag, input int count);
        return (int'(tag) < count);
    endfunction
endpackage

// File: rtl/sb_regfile_bits.sv
module sb_regfile_bits #(
    parameter int NUM_PREGS = 32,
    localparam int PREG_W = $clog2(NUM_PREGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_valid,
    input  logic [PREG_W-1:0]    set_idx,
    input  logic                 clr_valid,
    input  logic [PREG_W-1:0]    clr_idx,
    output logic [NUM_PREGS-1:0] ready_q
);
    logic [NUM_PREGS-1:0] ready_d;

    always_comb begin
        ready_d = ready_q;
        if (set_valid) ready_d[set_idx] = 1'b1;
        if (clr_valid) ready_d[clr_idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) ready_q <= '0;
        else     ready_q <= ready_d;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (ready_q == '0));

    // R4
    bcast_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (set_valid && !(clr_valid && clr_idx == set_idx)) |=> ready_q[$past(set_idx)]);

    // R7
    dst_clears_chk: assert property (@(posedge clk) disable iff (rst)
        clr_valid |=> !ready_q[$past(clr_idx)]);
endmodule

// File: rtl/sb_entry_slots.sv
module sb_entry_slots
    import sb_pkg::*;
#(
    parameter int NUM_SRCS = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      alloc,
    input  logic [NUM_SRCS-1:0]       alloc_wait,
    input  logic [NUM_SRCS*TAG_W-1:0] alloc_tag,
    input  tag_req_t                  wake,
    input  logic                      squash,
    output logic                      valid_q,
    output logic [NUM_SRCS-1:0]       wait_q,
    output logic [NUM_SRCS*TAG_W-1:0] tag_q,
    output logic                      ready
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            wait_q  <= '0;
            tag_q   <= '0;
        end else if (alloc) begin
            valid_q <= 1'b1;
            wait_q  <= alloc_wait;
            tag_q   <= alloc_tag;
        end else if (squash) begin
            valid_q <= 1'b0;
            wait_q  <= '0;
        end else begin
            for (int s = 0; s < NUM_SRCS; s++) begin
                if (wake.valid && wait_q[s] && tag_q[s*TAG_W +: TAG_W] == wake.tag)
                    wait_q[s] <= 1'b0;
            end
        end
    end

    assign ready = valid_q && (wait_q == '0);

    // R9
    squash_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (squash && !alloc) |=> (!valid_q && wait_q == '0));

    // R10
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_q && !alloc) |=> !ready);

    generate
        for (genvar s = 0; s < NUM_SRCS; s++) begin : g_slot_chk
            // R4
            slot_release_chk: assert property (@(posedge clk) disable iff (rst)
                (wake.valid && wait_q[s] && tag_q[s*TAG_W +: TAG_W] == wake.tag && !alloc && !squash)
                |=> !wait_q[s]);
        end
    endgenerate
endmodule

// File: rtl/sb_wakeup_unit.sv
module sb_wakeup_unit
    import sb_pkg::*;
#(
    parameter int NUM_INT_PREGS = 16,
    parameter int NUM_FP_PREGS  = 16,
    parameter int NUM_ENTRIES   = 8,
    parameter int NUM_SRCS      = 2,
    localparam int NUM_PREGS = NUM_INT_PREGS + NUM_FP_PREGS,
    localparam int PREG_W    = $clog2(NUM_PREGS),
    localparam int EIDX_W    = $clog2(NUM_ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ins_valid,
    input  logic [EIDX_W-1:0]         ins_entry,
    input  logic [NUM_SRCS*TAG_W-1:0] ins_src_tag,
    input  logic [NUM_SRCS-1:0]       ins_src_rdy,
    input  logic                      ins_dst_valid,
    input  logic [TAG_W-1:0]          ins_dst_tag,
    input  logic                      bcast_valid,
    input  logic [TAG_W-1:0]          bcast_tag,
    input  logic [NUM_ENTRIES-1:0]    squash_mask,
    output logic [NUM_ENTRIES-1:0]    entry_ready,
    output logic [NUM_PREGS-1:0]      reg_ready,
    output logic                      dst_conflict
);
    tag_req_t wake;
    tag_req_t dst;
    logic [NUM_SRCS-1:0] src_wait;
    logic [NUM_ENTRIES-1:0] ent_valid;
    logic [NUM_ENTRIES-1:0][NUM_SRCS-1:0] ent_wait;
    logic [NUM_ENTRIES-1:0][NUM_SRCS*TAG_W-1:0] ent_tag;
    logic conflict_d;

    assign wake.valid = bcast_valid && tag_tracked(bcast_tag, NUM_PREGS);
    assign wake.tag   = bcast_tag;
    assign dst.valid  = ins_valid && ins_dst_valid && tag_tracked(ins_dst_tag, NUM_PREGS);
    assign dst.tag    = ins_dst_tag;

    // Resolve each incoming source against front-end flag, range, scoreboard and broadcast.
    always_comb begin
        for (int s = 0; s < NUM_SRCS; s++) begin
            logic [TAG_W-1:0] t;
            t = ins_src_tag[s*TAG_W +: TAG_W];
            src_wait[s] = !(ins_src_rdy[s]
                            || !tag_tracked(t, NUM_PREGS)
                            || reg_ready[t[PREG_W-1:0]]
                            || (wake.valid && wake.tag == t));
        end
    end

    sb_regfile_bits #(.NUM_PREGS(NUM_PREGS)) u_bits (
        .clk      (clk),
        .rst      (rst),
        .set_valid(wake.valid),
        .set_idx  (wake.tag[PREG_W-1:0]),
        .clr_valid(dst.valid),
        .clr_idx  (dst.tag[PREG_W-1:0]),
        .ready_q  (reg_ready)
    );

    generate
        for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
            sb_entry_slots #(.NUM_SRCS(NUM_SRCS)) u_ent (
                .clk       (clk),
                .rst       (rst),
                .alloc     (ins_valid && ins_entry == EIDX_W'(e)),
                .alloc_wait(src_wait),
                .alloc_tag (ins_src_tag),
                .wake      (wake),
                .squash    (squash_mask[e]),
                .valid_q   (ent_valid[e]),
                .wait_q    (ent_wait[e]),
                .tag_q     (ent_tag[e]),
                .ready     (entry_ready[e])
            );
        end
    endgenerate

    // A new producer must not find consumers still waiting on its register.
    always_comb begin
        conflict_d = 1'b0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            for (int s = 0; s < NUM_SRCS; s++) begin
                if (ent_valid[e] && ent_wait[e][s] && ent_tag[e][s*TAG_W +: TAG_W] == dst.tag)
                    conflict_d = 1'b1;
            end
        end
        if (!dst.valid || (wake.valid && wake.tag == dst.tag)) conflict_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) dst_conflict <= 1'b0;
        else     dst_conflict <= conflict_d;
    end

    // R6
    untracked_bcast_chk: assert property (@(posedge clk) disable iff (rst)
        (bcast_valid && !tag_tracked(bcast_tag, NUM_PREGS) && !(ins_valid && ins_dst_valid))
        |=> $stable(reg_ready));

    // R8
    conflict_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !(ins_valid && ins_dst_valid) |=> !dst_conflict);
endmodule

// File: tb/tb_sb_wakeup_unit.sv
module tb_sb_wakeup_unit;
    localparam int TW = 6;

    typedef struct packed {
        logic          ins;
        logic [2:0]    ent;
        logic [TW-1:0] t0;
        logic          r0;
        logic [TW-1:0] t1;
        logic          r1;
        logic          dv;
        logic [TW-1:0] dt;
        logic          bv;
        logic [TW-1:0] bt;
        logic [7:0]    exp_rdy;
        logic [31:0]   exp_reg;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 6'd5,  1'b0, 6'd6,  1'b1, 1'b1, 6'd10, 1'b0, 6'd0,  8'h00, 32'h0000},
        '{1'b1, 3'd1, 6'd5,  1'b0, 6'd7,  1'b0, 1'b1, 6'd11, 1'b0, 6'd0,  8'h00, 32'h0000},
        '{1'b0, 3'd0, 6'd0,  1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b1, 6'd5,  8'h01, 32'h0020},
        '{1'b1, 3'd2, 6'd5,  1'b0, 6'd40, 1'b0, 1'b1, 6'd12, 1'b0, 6'd0,  8'h05, 32'h0020},
        '{1'b0, 3'd0, 6'd0,  1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b1, 6'd7,  8'h07, 32'h00A0},
        '{1'b1, 3'd3, 6'd9,  1'b0, 6'd9,  1'b0, 1'b1, 6'd13, 1'b1, 6'd9,  8'h0F, 32'h02A0},
        '{1'b1, 3'd4, 6'd13, 1'b0, 6'd12, 1'b0, 1'b1, 6'd14, 1'b0, 6'd0,  8'h0F, 32'h02A0},
        '{1'b0, 3'd0, 6'd0,  1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b1, 6'd13, 8'h0F, 32'h22A0},
        '{1'b0, 3'd0, 6'd0,  1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b1, 6'd50, 8'h0F, 32'h22A0},
        '{1'b0, 3'd0, 6'd0,  1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  1'b1, 6'd12, 8'h1F, 32'h32A0}
    };

    logic clk = 1'b0;
    logic rst;
    logic ins_valid;
    logic [2:0] ins_entry;
    logic [2*TW-1:0] ins_src_tag;
    logic [1:0] ins_src_rdy;
    logic ins_dst_valid;
    logic [TW-1:0] ins_dst_tag;
    logic bcast_valid;
    logic [TW-1:0] bcast_tag;
    logic [7:0] squash_mask;
    logic [7:0] entry_ready;
    logic [31:0] reg_ready;
    logic dst_conflict;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sb_wakeup_unit dut (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_entry(ins_entry),
        .ins_src_tag(ins_src_tag), .ins_src_rdy(ins_src_rdy),
        .ins_dst_valid(ins_dst_valid), .ins_dst_tag(ins_dst_tag),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .squash_mask(squash_mask),
        .entry_ready(entry_ready), .reg_ready(reg_ready), .dst_conflict(dst_conflict)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ins_valid = 0; ins_entry = 0; ins_src_tag = 0; ins_src_rdy = 0;
        ins_dst_valid = 0; ins_dst_tag = 0; bcast_valid = 0; bcast_tag = 0;
        squash_mask = 0;
    endtask

    task automatic insert(input logic [2:0] e, input logic [TW-1:0] t0, input logic r0,
                          input logic [TW-1:0] t1, input logic r1,
                          input logic dv, input logic [TW-1:0] dt);
        @(negedge clk);
        ins_valid = 1; ins_entry = e; ins_src_tag = {t1, t0}; ins_src_rdy = {r1, r0};
        ins_dst_valid = dv; ins_dst_tag = dt;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reg_ready", 64'(reg_ready), 64'h0);
        chk("R1 entry_ready", 64'(entry_ready), 64'h0);
        chk("R1 dst_conflict", 64'(dst_conflict), 64'h0);
        rst = 0;

        // R2 R3 R4 R5 R6 R7 R10 table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ins_valid = VECS[i].ins; ins_entry = VECS[i].ent;
            ins_src_tag = {VECS[i].t1, VECS[i].t0}; ins_src_rdy = {VECS[i].r1, VECS[i].r0};
            ins_dst_valid = VECS[i].dv; ins_dst_tag = VECS[i].dt;
            bcast_valid = VECS[i].bv; bcast_tag = VECS[i].bt;
            @(negedge clk);
            chk($sformatf("R3 R4 R5 entry_ready vec %0d", i), 64'(entry_ready), 64'(VECS[i].exp_rdy));
            chk($sformatf("R2 R6 R7 reg_ready vec %0d", i), 64'(reg_ready), 64'(VECS[i].exp_reg));
            idle();
        end

        // R9 squash empties entries, scoreboard untouched
        insert(3'd5, 6'd20, 1'b0, 6'd21, 1'b0, 1'b1, 6'd22);
        idle();
        @(negedge clk);
        squash_mask = 8'h21;
        @(negedge clk);
        chk("R9 entry_ready after squash", 64'(entry_ready), 64'h1E);
        chk("R9 reg_ready after squash", 64'(reg_ready), 64'h32A0);
        idle();
        @(negedge clk);
        bcast_valid = 1; bcast_tag = 6'd20;
        @(negedge clk);
        chk("R9 squashed entry stays unready", 64'(entry_ready), 64'h1E);
        chk("R4 reg_ready bit 20", 64'(reg_ready), 64'h1032A0);
        idle();

        // R8 destination conflict
        insert(3'd6, 6'd30, 1'b0, 6'd0, 1'b1, 1'b1, 6'd31);
        chk("R8 no conflict", 64'(dst_conflict), 64'h0);
        chk("R3 e6 waiting", 64'(entry_ready), 64'h1E);
        insert(3'd7, 6'd1, 1'b1, 6'd2, 1'b1, 1'b1, 6'd30);
        chk("R8 conflict raised", 64'(dst_conflict), 64'h1);
        chk("R10 e7 ready", 64'(entry_ready), 64'h9E);
        idle();
        @(negedge clk);
        chk("R8 conflict one cycle", 64'(dst_conflict), 64'h0);

        // R7 destination clears a set bit
        insert(3'd7, 6'd1, 1'b1, 6'd2, 1'b1, 1'b1, 6'd5);
        chk("R7 reg5 cleared", 64'(reg_ready), 64'h103280);
        idle();

        // R6 untracked destination changes nothing
        insert(3'd6, 6'd1, 1'b1, 6'd2, 1'b1, 1'b1, 6'd45);
        chk("R6 untracked dst", 64'(reg_ready), 64'h103280);
        chk("R10 e6 ready", 64'(entry_ready), 64'hDE);
        idle();

        // R1 reset mid-run
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        chk("R1 reset reg_ready", 64'(reg_ready), 64'h0);
        chk("R1 reset entry_ready", 64'(entry_ready), 64'h0);
        rst = 0;

        done = 1;
        finish_run();
    end
endmodule